// File: doc/BRIEF.md
# Dual-I/O Serial Flash Read Controller

This block is the host side of a serial flash read path. A client presents a 24-bit start address and a byte count on a simple request handshake. The controller then pulls chip select low and sends the 8-bit read opcode 0xBB on IO0, one bit per serial clock. It sends the address two bits per clock and four clocks of dummy zeros. It then releases both data lines and collects the bytes the flash returns, two bits per clock, into a valid/ready byte stream.

The serial clock is divided down from the system clock and idles low. The controller changes its outputs when SCK falls and samples input pairs when SCK rises. If the stream consumer stops accepting bytes, the serial clock is paused in its low phase, so no returned data is lost. The flash walks through consecutive addresses on its own, wrapping past the top of its space. The controller only keeps clocking until the requested number of bytes has arrived, then raises chip select and waits one SCK period before it accepts the next request.

Top module: `dual_io_flash_reader`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, io0_oe and io1_oe are 0, out_valid is 0 and req_ready is 1.
- R2: req_ready is 1 only while the controller is idle. A request is taken only when req_valid and req_ready are both 1. req_valid raised during a transaction has no effect on that transaction's address or length.
- R3: The first 8 SCK rising edges after cs_n falls carry opcode 0xBB on io0_o, most significant bit first. During these edges io0_oe is 1 and io1_oe is 0.
- R4: Rising edges 9 to 20 carry the address two bits per edge, highest pair first. io1_o carries the odd bit (A23, A21 … A1) and io0_o the even bit (A22, A20 … A0). Both output enables are 1.
- R5: Rising edges 21 to 24 are dummy clocks with both lines driven to 0. Both output enables drop to 0 when SCK rises on edge 24, before the falling edge that starts data, and stay 0 for the rest of the transaction.
- R6: Each returned byte takes 4 rising edges. On each edge io1_i gives D7, D5, D3, D1 and io0_i gives D6, D4, D2, D0, in that order. Bytes appear on out_data in arrival order. A byte offered with out_ready low holds out_valid and out_data unchanged.
- R7: A transaction has exactly 24 + 4*L rising edges of SCK, where L is req_len, or 1 when req_len is 0. cs_n then returns to 1.
- R8: SCK is low whenever cs_n is 1. Each high phase lasts CLK_DIV/2 system clocks. Driven data changes only when SCK falls.
- R9: cs_n stays high for at least CLK_DIV system clocks between two transactions.
- R10: While a byte is waiting with out_ready low in the data phase, SCK does not rise. No byte is lost or duplicated under backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Byte count, 0 means one byte |
| out_valid | output | 1 | Returned byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Returned byte |
| sck | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| io0_o | output | 1 | Data line 0 output value |
| io0_oe | output | 1 | Data line 0 output enable |
| io0_i | input | 1 | Data line 0 input value |
| io1_o | output | 1 | Data line 1 output value |
| io1_oe | output | 1 | Data line 1 output enable |
| io1_i | input | 1 | Data line 1 input value |

## Verification
Take the system clock edge that accepts a request as edge 0. Rising edge n of SCK (counted from 0) then lands HALF + n*CLK_DIV system clocks later, with HALF = CLK_DIV/2. Byte k becomes valid one clock after rising edge 27+4k, and cs_n rises CLK_DIV*(24+4L) clocks after acceptance when there is no stall. The bench's flash model reacts to the SCK edges themselves. It samples host bits on each rise and drives the next pair on each fall, so it stays in step with these latencies even when backpressure stretches the low phase. A scoreboard matches returned bytes in order, whenever the handshake fires. Edge counts, high-phase widths and chip-select gaps are measured in absolute time and checked once per transaction.

// File: rtl/dfr_pkg.sv
`timescale 1ns/1ps
package dfr_pkg;
  localparam logic [7:0]  RD_OPCODE  = 8'hBB;
  localparam int unsigned CMD_CLKS   = 8;
  localparam int unsigned ADDR_CLKS  = 12;
  localparam int unsigned HDR_CLKS   = 24;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} seq_st_t;

  // zero requests one byte
  function automatic int unsigned eff_len(int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction

  // index of the final SCK cycle of a transaction
  function automatic int unsigned last_cyc(int unsigned n);
    return HDR_CLKS - 1 + 4 * eff_len(n);
  endfunction

  // pin drive for SCK cycle n: {oe1, o1, oe0, o0}
  function automatic logic [3:0] pin_drive(int unsigned n, logic [23:0] a, logic sck_hi);
    logic [3:0] r;
    int unsigned k;
    r = 4'b0000;
    k = 0;
    if (n < CMD_CLKS) begin
      r = {1'b0, 1'b0, 1'b1, RD_OPCODE[3'(7 - n)]};
    end else if (n < CMD_CLKS + ADDR_CLKS) begin
      k = n - CMD_CLKS;
      r = {1'b1, a[5'(23 - 2 * k)], 1'b1, a[5'(22 - 2 * k)]};
    end else if (n < HDR_CLKS - 1 || (n == HDR_CLKS - 1 && !sck_hi)) begin
      r = 4'b1010;
    end
    return r;
  endfunction
endpackage

// File: rtl/dfr_sck_gen.sv
`timescale 1ns/1ps
module dfr_sck_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hold,
  output logic sck,
  output logic rise,
  output logic fall
);
  localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [TW-1:0] tcnt;
  logic          at_end;

  assign at_end = (tcnt == TW'(HALF - 1));
  assign rise   = run && at_end && !sck && !hold;
  assign fall   = run && at_end && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      sck  <= 1'b0;
    end else if (!run) begin
      tcnt <= '0;
      sck  <= 1'b0;
    end else if (rise || fall) begin
      tcnt <= '0;
      sck  <= ~sck;
    end else if (!at_end) begin
      tcnt <= tcnt + TW'(1);
    end
  end

  // R10
  stall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && run && !sck) |=> !sck);
endmodule

// File: rtl/dfr_sequencer.sv
`timescale 1ns/1ps
module dfr_sequencer
  import dfr_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int GAP   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             rise,
  input  logic             fall,
  input  logic             sck,
  output logic             run,
  output logic             hold,
  output logic             cs_n,
  output logic             io0_o,
  output logic             io0_oe,
  output logic             io1_o,
  output logic             io1_oe,
  input  logic             io0_i,
  input  logic             io1_i,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data
);
  localparam int CYC_W = LEN_W + 3;
  localparam int GW    = $clog2(GAP + 1);

  seq_st_t          st;
  logic [CYC_W-1:0] cyc, last_q;
  logic [23:0]      addr_q;
  logic [5:0]       sh;
  logic [GW-1:0]    gcnt;
  logic             cs_q;
  logic             data_phase;
  logic             cap_byte;
  logic [3:0]       drv;

  assign req_ready  = (st == ST_IDLE);
  assign run        = (st == ST_RUN);
  assign cs_n       = cs_q;
  assign data_phase = run && (cyc >= CYC_W'(HDR_CLKS));
  assign cap_byte   = rise && data_phase && (cyc[1:0] == 2'd3);
  assign hold       = data_phase && out_valid && !out_ready;
  assign drv        = run ? pin_drive(32'(cyc), addr_q, sck) : 4'b0000;
  assign io1_oe     = drv[3];
  assign io1_o      = drv[2];
  assign io0_oe     = drv[1];
  assign io0_o      = drv[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cs_q   <= 1'b1;
      cyc    <= '0;
      last_q <= '0;
      addr_q <= '0;
      sh     <= '0;
      gcnt   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          last_q <= CYC_W'(last_cyc(32'(req_len)));
          cyc    <= '0;
          cs_q   <= 1'b0;
          st     <= ST_RUN;
        end
        ST_RUN: begin
          if (rise && data_phase) sh <= {sh[3:0], io1_i, io0_i};
          if (fall) begin
            if (cyc == last_q) begin
              cs_q <= 1'b1;
              gcnt <= '0;
              st   <= ST_GAP;
            end else begin
              cyc <= cyc + CYC_W'(1);
            end
          end
        end
        ST_GAP: begin
          gcnt <= gcnt + GW'(1);
          if (gcnt == GW'(GAP - 1)) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (cap_byte) begin
      out_valid <= 1'b1;
      out_data  <= {sh, io1_i, io0_i};
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R5
  rx_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sck) && data_phase) |-> (!io0_oe && !io1_oe));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_q && $past(!cs_q) && !$stable(io0_o)) |-> $fell(sck));
endmodule

// File: rtl/dual_io_flash_reader.sv
`timescale 1ns/1ps
module dual_io_flash_reader #(
  parameter int CLK_DIV = 4,
  parameter int LEN_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             sck,
  output logic             cs_n,
  output logic             io0_o,
  output logic             io0_oe,
  input  logic             io0_i,
  output logic             io1_o,
  output logic             io1_oe,
  input  logic             io1_i
);
  localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;

  logic sck_rise, sck_fall, seq_run, seq_hold;

  dfr_sck_gen #(.HALF(HALF)) u_sck (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (seq_run),
    .hold (seq_hold),
    .sck  (sck),
    .rise (sck_rise),
    .fall (sck_fall)
  );

  dfr_sequencer #(.LEN_W(LEN_W), .GAP(2 * HALF)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_addr (req_addr),
    .req_len  (req_len),
    .rise     (sck_rise),
    .fall     (sck_fall),
    .sck      (sck),
    .run      (seq_run),
    .hold     (seq_hold),
    .cs_n     (cs_n),
    .io0_o    (io0_o),
    .io0_oe   (io0_oe),
    .io1_o    (io1_o),
    .io1_oe   (io1_oe),
    .io0_i    (io0_i),
    .io1_i    (io1_i),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
  );

  // R8
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R2
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(req_valid && req_ready));
endmodule

// File: tb/sim_dual_io_flash_reader.sv
`timescale 1ns/1ps
module sim_dual_io_flash_reader;
  localparam int CLK_DIV = 4;
  localparam int LEN_W   = 16;
  localparam int HALF    = CLK_DIV / 2;
  localparam int TCK     = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, out_ready = 1'b1;
  logic [23:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_ready, out_valid, sck, cs_n, io0_o, io0_oe, io1_o, io1_oe;
  logic [7:0] out_data;
  logic io0_i = 1'b0, io1_i = 1'b0;

  int nchk = 0, nfail = 0, wd = 0, mode = 0, exp_edges = 0, idle_bad = 0;
  logic [23:0] exp_addr = '0;
  logic [7:0] expq[$];

  always #(TCK / 2) clk = ~clk;

  dual_io_flash_reader #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .sck(sck), .cs_n(cs_n),
    .io0_o(io0_o), .io0_oe(io0_oe), .io0_i(io0_i),
    .io1_o(io1_o), .io1_oe(io1_oe), .io1_i(io1_i));

  function automatic logic [7:0] mem_byte(logic [23:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      nfail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  // flash model
  int sc = 0;
  bit active = 0, cmd_ok = 1, dum_ok = 1, rel_ok = 1, hi_ok = 1;
  logic [7:0] op;
  logic [23:0] ra;
  time t_rise = 0, t_cs_up = 0;

  always @(negedge cs_n) begin
    if (active) chk(($time - t_cs_up) >= CLK_DIV * TCK, "R9 cs_n gap ns", $time - t_cs_up, CLK_DIV * TCK);
    active = 1; sc = 0; op = '0; ra = '0;
    cmd_ok = 1; dum_ok = 1; rel_ok = 1; hi_ok = 1;
  end

  always @(posedge sck) if (!cs_n) begin
    t_rise = $time;
    if (sc < 8) begin
      op = {op[6:0], io0_o};
      if (!(io0_oe && !io1_oe)) cmd_ok = 0;
    end else if (sc < 20) begin
      ra = {ra[21:0], io1_o, io0_o};
      if (!(io0_oe && io1_oe)) cmd_ok = 0;
    end else if (sc < 23) begin
      if (io0_o || io1_o || !io0_oe || !io1_oe) dum_ok = 0;
    end
    if (sc == 20) begin
      chk(op == 8'hBB, "R3 opcode", op, 8'hBB);
      chk(ra == exp_addr, "R4 address", ra, exp_addr);
      chk(cmd_ok, "R3/R4 output enables", cmd_ok, 1);
    end
    sc++;
  end

  always @(negedge sck) if (!cs_n) begin
    int d;
    logic [7:0] b;
    if (($time - t_rise) != HALF * TCK) hi_ok = 0;
    if (sc >= 24) begin
      if (io0_oe || io1_oe) rel_ok = 0;
      d = sc - 24;
      b = mem_byte(exp_addr + 24'(d / 4));
      io1_i <= b[7 - 2 * (d % 4)];
      io0_i <= b[6 - 2 * (d % 4)];
    end
  end

  always @(posedge cs_n) if (active) begin
    t_cs_up = $time;
    chk(sc == exp_edges, "R7 sck rising edges", sc, exp_edges);
    chk(dum_ok, "R5 dummy zeros", dum_ok, 1);
    chk(rel_ok, "R5 lines released", rel_ok, 1);
    chk(hi_ok, "R8 sck high width", hi_ok, 1);
  end

  // consumer + scoreboard monitor
  always @(negedge clk) begin
    case (mode)
      0: out_ready = 1'b1;
      1: out_ready = 1'($urandom % 2);
      default: out_ready = ((($time / TCK) % 64) >= 40);
    endcase
    if (cs_n && sck) idle_bad++;
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        chk(0, "R6 unexpected byte", out_data, 0);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(out_data == e, (mode == 0) ? "R6 byte" : "R10 byte under backpressure", out_data, e);
      end
    end
  end

  task automatic run_txn(logic [23:0] a, int unsigned n, int m);
    int unsigned L;
    L = (n == 0) ? 1 : n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    mode = m;
    exp_addr = a;
    exp_edges = 24 + 4 * int'(L);
    for (int i = 0; i < int'(L); i++) expq.push_back(mem_byte(a + 24'(i)));
    req_addr = a; req_len = LEN_W'(n); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge cs_n);
    while (expq.size() != 0) @(negedge clk);
    chk(expq.size() == 0, "R10 all bytes delivered", expq.size(), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(cs_n == 1 && sck == 0, "R1 cs_n/sck in reset", {cs_n, sck}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!io0_oe && !io1_oe, "R1 output enables", {io1_oe, io0_oe}, 0);
    chk(!out_valid && req_ready, "R1 valid/ready", {out_valid, req_ready}, 2'b01);

    run_txn(24'h123456, 1, 0);
    run_txn(24'hABCDEF, 0, 0);          // R7 zero length
    run_txn(24'h000100, 16, 0);

    fork                                // R2 request during busy ignored
      run_txn(24'h0F0F3C, 5, 0);
      begin
        @(negedge cs_n);
        repeat (10) @(negedge clk);
        req_addr = 24'h777777; req_len = LEN_W'(9); req_valid = 1'b1;
        repeat (4) begin
          @(negedge clk);
          chk(!req_ready, "R2 ready low while busy", req_ready, 0);
        end
        req_valid = 1'b0;
      end
    join

    run_txn(24'h5A5A00, 24, 1);         // R10 random backpressure
    run_txn(24'h3C0001, 12, 2);         // R10 long stalls
    run_txn(24'hFFFFFD, 6, 0);          // R6 burst across top of space
    run_txn(24'h000010, 2, 0);          // R9 back to back
    run_txn(24'h000020, 3, 0);

    repeat (20) @(negedge clk);
    chk(idle_bad == 0, "R8 sck low while deselected", idle_bad, 0);
    chk(req_ready && cs_n, "R2 idle after run", {req_ready, cs_n}, 2'b11);
    summary();
    $finish;
  end
endmodule